// File: doc/BRIEF.md
# Instruction Decode Stage with Skid Buffer

This block is the pipeline stage between instruction fetch and register rename in a cycle-level out-of-order core. Each cycle it takes a group of up to four instruction records from fetch and hands the live ones to rename, oldest first and packed from slot 0. Each record already carries its control-type flags, its prediction and its real target. When rename pushes back, incoming groups are parked in a small skid buffer, and fetch is held off until that buffer has drained.

The stage screens each group as it passes through. Records that are already marked squashed are dropped and counted. Two kinds of bad prediction are caught here: a record predicted taken that is not a control instruction, and a direct unconditional jump that reads and writes no registers whose predicted next PC is wrong. For either one, the stage sends fetch a one-cycle redirect message and then sits in a squashing state. A squash from commit clears the stage at any time. Free-running counters record idle, blocked, unblocking and squashing cycles, both kinds of misprediction, the records passed on and the records skipped.

Top module: `decode_stage`

## Requirements
- R1: Record layout, MSB first, 70 bits: valid, squashed, pc[16], seq[16], pred_taken, pred_tgt[16], is_ctrl, dir_uncond, reg_free, real_tgt[16]. Slot k of a group occupies bits [70k+69:70k], and slot 0 is the oldest. Records passed to rename appear one cycle after the group is accepted, packed from slot 0 in their original order, with `rn_valid` marking them and unused slots all zero. After reset every output and counter is zero.
- R2: A valid record with squashed=1 is not passed on. Each such record adds one to `cnt_squashed`.
- R3: A record with pred_taken=1 and is_ctrl=0 is passed on, and every later slot of its group is dropped. A redirect is sent to its pc+4, and `cnt_ctl_mispred` goes up by one.
- R4: A record with is_ctrl, dir_uncond and reg_free all set is resolved in this stage. If pred_taken=0, or if pred_tgt differs from real_tgt, the record is passed on and later slots are dropped. A redirect is sent to real_tgt, and `cnt_br_mispred` goes up by one. A record that lacks any of the three flags is never resolved.
- R5: A redirect sets `redir_squash`, `redir_mispred` and `redir_taken` together for exactly one cycle, with `redir_seq` set to the offending record's seq. The cycle after it is a squashing cycle in which the fetch input is ignored.
- R6: A non-empty group that arrives while `rn_stall` is high is stored, not passed on. `fe_stall` is high from the next cycle for as long as the skid buffer holds any group.
- R7: After `rn_stall` falls, one cycle passes with no output. Then the stored groups are emitted one per cycle, oldest first, and `fe_stall` falls in the cycle the last one appears.
- R8: `cm_squash` or `cm_rob_squashing` empties the skid buffer and drops the input. The stage stays in squashing until a cycle in which both are low. `cnt_squash_cyc` counts the cycles spent in squashing.
- R9: `cnt_idle` counts cycles in which the input group has no valid record, the state is neither blocked, unblocking nor squashing, and rename is not stalling.
- R10: `cnt_blocked` and `cnt_unblock` count the cycles spent in those states. `cnt_decoded` counts every record passed to rename.
- R11: The skid buffer never receives a group while it is full and not being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_group | input | 280 | Instruction group from fetch |
| fe_stall | output | 1 | Hold-off to fetch while the skid buffer is occupied |
| rn_stall | input | 1 | Back-pressure from rename |
| rn_group | output | 280 | Records passed to rename |
| rn_valid | output | 4 | Valid mask of rn_group slots |
| cm_squash | input | 1 | Squash request from commit |
| cm_rob_squashing | input | 1 | Reorder buffer squash in progress |
| redir_squash | output | 1 | Redirect message: squash |
| redir_mispred | output | 1 | Redirect message: misprediction |
| redir_taken | output | 1 | Redirect message: taken |
| redir_seq | output | 16 | Sequence number of the offending record |
| redir_pc | output | 16 | Correct next PC for fetch |
| cnt_idle | output | 32 | Idle cycles |
| cnt_blocked | output | 32 | Blocked cycles |
| cnt_unblock | output | 32 | Unblocking cycles |
| cnt_squash_cyc | output | 32 | Squashing cycles |
| cnt_br_mispred | output | 32 | Early-resolved jump mispredictions |
| cnt_ctl_mispred | output | 32 | Non-control records predicted taken |
| cnt_decoded | output | 32 | Records passed to rename |
| cnt_squashed | output | 32 | Squashed records skipped |

## Verification
The hardest case to reach is a skid buffer holding more than one group. Fetch only sees the stall one cycle late, so the stimulus acts as a fetch unit that sends a second group in that lag cycle. It then releases rename and checks that the two groups drain in order, with the stall held until the second one appears. A commit squash is also raised while a group is still parked, which shows that the buffer is emptied. Random groups, seeded and weighted towards squashed records, non-control records predicted taken and register-free jumps with wrong targets, are checked against a bench-side screening function.

// File: rtl/decode_pkg.sv
package decode_pkg;

    localparam int PC_W  = 16;
    localparam int SEQ_W = 16;
    localparam int CNT_W = 32;
    localparam logic [PC_W-1:0] INST_BYTES = 16'd4;

    typedef struct packed {
        logic             valid;
        logic             squashed;
        logic [PC_W-1:0]  pc;
        logic [SEQ_W-1:0] seq;
        logic             pred_taken;
        logic [PC_W-1:0]  pred_tgt;
        logic             is_ctrl;
        logic             dir_uncond;
        logic             reg_free;
        logic [PC_W-1:0]  real_tgt;
    } inst_rec_t;

    localparam int REC_W = $bits(inst_rec_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_BLOCK,
        ST_UNBLOCK,
        ST_SQUASH
    } dec_state_e;

    // Counter slot indices
    localparam int C_IDLE    = 0;
    localparam int C_BLOCK   = 1;
    localparam int C_UNBLOCK = 2;
    localparam int C_SQUASH  = 3;
    localparam int C_BR      = 4;
    localparam int C_CTL     = 5;
    localparam int C_DEC     = 6;
    localparam int C_SKIP    = 7;
    localparam int NUM_CNT   = 8;

    function automatic logic early_resolvable(inst_rec_t r);
        return r.is_ctrl && r.dir_uncond && r.reg_free;
    endfunction

    function automatic logic jump_wrong(inst_rec_t r);
        return !r.pred_taken || (r.pred_tgt != r.real_tgt);
    endfunction

endpackage

// File: rtl/decode_skid.sv
module decode_skid #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             clear,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_ptr, wr_ptr;
    logic             pop_eff, push_eff;

    assign empty    = (count == '0);
    assign full     = (count == CW'(DEPTH));
    assign pop_eff  = pop && !empty;
    assign push_eff = push && (!full || pop_eff);
    assign head     = mem[rd_ptr];

    function automatic logic [AW-1:0] wrap_inc(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_eff) begin
                wr_ptr <= wrap_inc(wr_ptr);
            end
            if (pop_eff) begin
                rd_ptr <= wrap_inc(rd_ptr);
            end
            count <= count + CW'(push_eff) - CW'(pop_eff);
        end
    end

    always_ff @(posedge clk) begin
        if (push_eff && !clear && !rst) begin
            mem[wr_ptr] <= din;
        end
    end

endmodule

// File: rtl/decode_resolve.sv
module decode_resolve
    import decode_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int CW    = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS*REC_W-1:0] grp,
    output logic [SLOTS*REC_W-1:0] out_grp,
    output logic [SLOTS-1:0]       out_valid,
    output logic [CW-1:0]          n_pass,
    output logic [CW-1:0]          n_skip,
    output logic                   hit,
    output logic                   hit_ctl,
    output logic                   hit_br,
    output logic [PC_W-1:0]        fix_pc,
    output logic [SEQ_W-1:0]       fix_seq
);
    always_comb begin
        logic      stop;
        int        n;
        inst_rec_t rec;
        stop      = 1'b0;
        n         = 0;
        out_grp   = '0;
        out_valid = '0;
        n_skip    = '0;
        hit       = 1'b0;
        hit_ctl   = 1'b0;
        hit_br    = 1'b0;
        fix_pc    = '0;
        fix_seq   = '0;
        for (int i = 0; i < SLOTS; i++) begin
            rec = grp[i*REC_W +: REC_W];
            if (!stop && rec.valid) begin
                if (rec.squashed) begin
                    n_skip = n_skip + CW'(1);
                end else begin
                    out_grp[n*REC_W +: REC_W] = rec;
                    out_valid[n] = 1'b1;
                    n = n + 1;
                    if (rec.pred_taken && !rec.is_ctrl) begin
                        hit     = 1'b1;
                        hit_ctl = 1'b1;
                        fix_pc  = rec.pc + INST_BYTES;
                        fix_seq = rec.seq;
                        stop    = 1'b1;
                    end else if (early_resolvable(rec) && jump_wrong(rec)) begin
                        hit     = 1'b1;
                        hit_br  = 1'b1;
                        fix_pc  = rec.real_tgt;
                        fix_seq = rec.seq;
                        stop    = 1'b1;
                    end
                end
            end
        end
        n_pass = CW'(n);
    end

endmodule

// File: rtl/decode_counters.sv
module decode_counters
    import decode_pkg::*;
#(
    parameter int NUM = 8,
    parameter int IW  = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM-1:0][IW-1:0]    inc,
    output logic [NUM-1:0][CNT_W-1:0] cnt
);
    for (genvar g = 0; g < NUM; g++) begin : g_cnt
        logic [CNT_W-1:0] c_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                c_q <= '0;
            end else begin
                c_q <= c_q + CNT_W'(inc[g]);
            end
        end
        assign cnt[g] = c_q;
    end

endmodule

// File: rtl/decode_stage.sv
module decode_stage
    import decode_pkg::*;
#(
    parameter int SLOTS      = 4,
    parameter int SKID_DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SLOTS*REC_W-1:0] fe_group,
    output logic                   fe_stall,
    input  logic                   rn_stall,
    output logic [SLOTS*REC_W-1:0] rn_group,
    output logic [SLOTS-1:0]       rn_valid,
    input  logic                   cm_squash,
    input  logic                   cm_rob_squashing,
    output logic                   redir_squash,
    output logic                   redir_mispred,
    output logic                   redir_taken,
    output logic [SEQ_W-1:0]       redir_seq,
    output logic [PC_W-1:0]        redir_pc,
    output logic [CNT_W-1:0]       cnt_idle,
    output logic [CNT_W-1:0]       cnt_blocked,
    output logic [CNT_W-1:0]       cnt_unblock,
    output logic [CNT_W-1:0]       cnt_squash_cyc,
    output logic [CNT_W-1:0]       cnt_br_mispred,
    output logic [CNT_W-1:0]       cnt_ctl_mispred,
    output logic [CNT_W-1:0]       cnt_decoded,
    output logic [CNT_W-1:0]       cnt_squashed
);
    localparam int GW  = SLOTS * REC_W;
    localparam int SCW = $clog2(SKID_DEPTH + 1);
    localparam int NCW = $clog2(SLOTS + 1);

    dec_state_e state_q, state_d;

    logic           in_any;
    logic           cm_any;
    logic           skid_push, skid_pop, skid_clr;
    logic [GW-1:0]  skid_head;
    logic [SCW-1:0] skid_cnt;
    logic           skid_empty, skid_full;
    logic           do_proc, from_skid, idle_cyc;
    logic [GW-1:0]  proc_grp;

    logic [GW-1:0]     r_grp;
    logic [SLOTS-1:0]  r_valid;
    logic [NCW-1:0]    r_pass, r_skip;
    logic              r_hit, r_ctl, r_br;
    logic [PC_W-1:0]   r_pc;
    logic [SEQ_W-1:0]  r_seq;

    // Any live slot in the fetch group
    always_comb begin
        in_any = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            in_any = in_any | fe_group[i*REC_W + REC_W - 1];
        end
    end

    assign cm_any   = cm_squash || cm_rob_squashing;
    assign proc_grp = from_skid ? skid_head : fe_group;

    decode_resolve #(.SLOTS(SLOTS), .CW(NCW)) u_resolve (
        .grp       (proc_grp),
        .out_grp   (r_grp),
        .out_valid (r_valid),
        .n_pass    (r_pass),
        .n_skip    (r_skip),
        .hit       (r_hit),
        .hit_ctl   (r_ctl),
        .hit_br    (r_br),
        .fix_pc    (r_pc),
        .fix_seq   (r_seq)
    );

    // Controller
    always_comb begin
        logic push_raw;
        state_d   = state_q;
        push_raw  = 1'b0;
        skid_pop  = 1'b0;
        skid_clr  = 1'b0;
        do_proc   = 1'b0;
        from_skid = 1'b0;
        idle_cyc  = 1'b0;
        if (cm_any) begin
            skid_clr = 1'b1;
            state_d  = ST_SQUASH;
        end else begin
            unique case (state_q)
                ST_SQUASH: begin
                    state_d = ST_RUN;
                end
                ST_BLOCK: begin
                    push_raw = in_any;
                    if (!rn_stall) begin
                        state_d = ST_UNBLOCK;
                    end
                end
                ST_UNBLOCK: begin
                    push_raw = in_any;
                    if (rn_stall) begin
                        state_d = ST_BLOCK;
                    end else if (skid_empty) begin
                        state_d = ST_RUN;
                    end else begin
                        skid_pop  = 1'b1;
                        do_proc   = 1'b1;
                        from_skid = 1'b1;
                        if (skid_cnt == SCW'(1) && !in_any) begin
                            state_d = ST_RUN;
                        end
                    end
                end
                default: begin
                    if (rn_stall) begin
                        push_raw = in_any;
                        state_d  = ST_BLOCK;
                    end else if (!in_any) begin
                        idle_cyc = 1'b1;
                        state_d  = ST_IDLE;
                    end else begin
                        do_proc = 1'b1;
                        state_d = ST_RUN;
                    end
                end
            endcase
            if (do_proc && r_hit) begin
                skid_clr = 1'b1;
                state_d  = ST_SQUASH;
            end
        end
        skid_push = push_raw && !skid_clr;
    end

    decode_skid #(.DEPTH(SKID_DEPTH), .WIDTH(GW), .CW(SCW)) u_skid (
        .clk   (clk),
        .rst   (rst),
        .push  (skid_push),
        .pop   (skid_pop),
        .clear (skid_clr),
        .din   (fe_group),
        .head  (skid_head),
        .count (skid_cnt),
        .empty (skid_empty),
        .full  (skid_full)
    );

    assign fe_stall = !skid_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            rn_valid      <= '0;
            rn_group      <= '0;
            redir_squash  <= 1'b0;
            redir_mispred <= 1'b0;
            redir_taken   <= 1'b0;
            redir_seq     <= '0;
            redir_pc      <= '0;
        end else begin
            state_q       <= state_d;
            rn_valid      <= do_proc ? r_valid : '0;
            rn_group      <= do_proc ? r_grp : '0;
            redir_squash  <= do_proc && r_hit;
            redir_mispred <= do_proc && r_hit;
            redir_taken   <= do_proc && r_hit;
            redir_seq     <= (do_proc && r_hit) ? r_seq : '0;
            redir_pc      <= (do_proc && r_hit) ? r_pc : '0;
        end
    end

    // Event counters
    logic [NUM_CNT-1:0][NCW-1:0]   inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt;

    always_comb begin
        inc          = '0;
        inc[C_IDLE]    = NCW'(idle_cyc);
        inc[C_BLOCK]   = NCW'(state_q == ST_BLOCK);
        inc[C_UNBLOCK] = NCW'(state_q == ST_UNBLOCK);
        inc[C_SQUASH]  = NCW'(state_q == ST_SQUASH);
        inc[C_BR]      = NCW'(do_proc && r_br);
        inc[C_CTL]     = NCW'(do_proc && r_ctl);
        inc[C_DEC]     = do_proc ? r_pass : '0;
        inc[C_SKIP]    = do_proc ? r_skip : '0;
    end

    decode_counters #(.NUM(NUM_CNT), .IW(NCW)) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (inc),
        .cnt (cnt)
    );

    assign cnt_idle        = cnt[C_IDLE];
    assign cnt_blocked     = cnt[C_BLOCK];
    assign cnt_unblock     = cnt[C_UNBLOCK];
    assign cnt_squash_cyc  = cnt[C_SQUASH];
    assign cnt_br_mispred  = cnt[C_BR];
    assign cnt_ctl_mispred = cnt[C_CTL];
    assign cnt_decoded     = cnt[C_DEC];
    assign cnt_squashed    = cnt[C_SKIP];

endmodule

// File: rtl/decode_stage_chk.sv
module decode_stage_chk
    import decode_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_any,
    input logic             rn_stall,
    input logic             cm_squash,
    input logic             cm_rob_squashing,
    input logic             fe_stall,
    input logic [SLOTS-1:0] rn_valid,
    input logic             redir_squash,
    input dec_state_e       state_q,
    input logic             skid_push,
    input logic             skid_pop,
    input logic             skid_full
);
    // R6
    stall_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (rn_stall && in_any && !cm_squash && !cm_rob_squashing && state_q != ST_SQUASH)
        |=> fe_stall);

    // R6
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rn_stall |=> (rn_valid == '0));

    // R5
    redir_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        redir_squash |=> !redir_squash);

    // R5
    redir_state_chk: assert property (@(posedge clk) disable iff (rst)
        redir_squash |-> (state_q == ST_SQUASH));

    // R8
    commit_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (cm_squash || cm_rob_squashing) |=> (rn_valid == '0 && !fe_stall && !redir_squash));

    // R1
    rn_packed_chk: assert property (@(posedge clk) disable iff (rst)
        ((rn_valid & (rn_valid + SLOTS'(1))) == '0));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !(skid_full && skid_push && !skid_pop));

endmodule

bind decode_stage decode_stage_chk #(.SLOTS(SLOTS)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .in_any           (in_any),
    .rn_stall         (rn_stall),
    .cm_squash        (cm_squash),
    .cm_rob_squashing (cm_rob_squashing),
    .fe_stall         (fe_stall),
    .rn_valid         (rn_valid),
    .redir_squash     (redir_squash),
    .state_q          (state_q),
    .skid_push        (skid_push),
    .skid_pop         (skid_pop),
    .skid_full        (skid_full)
);

// File: tb/decode_stage_test.sv
`timescale 1ns/1ps
module decode_stage_test;
    import decode_pkg::*;

    localparam int N  = 4;
    localparam int GW = N * REC_W;

    typedef inst_rec_t grp_t [N];

    logic clk = 1'b0;
    logic rst;
    always #5 clk = ~clk;

    logic [GW-1:0]  fe_group;
    logic           fe_stall, rn_stall, cm_squash, cm_rob_squashing;
    logic [GW-1:0]  rn_group;
    logic [N-1:0]   rn_valid;
    logic           redir_squash, redir_mispred, redir_taken;
    logic [15:0]    redir_seq, redir_pc;
    logic [31:0]    cnt_idle, cnt_blocked, cnt_unblock, cnt_squash_cyc;
    logic [31:0]    cnt_br_mispred, cnt_ctl_mispred, cnt_decoded, cnt_squashed;

    decode_stage #(.SLOTS(N), .SKID_DEPTH(4)) uut (
        .clk(clk), .rst(rst), .fe_group(fe_group), .fe_stall(fe_stall),
        .rn_stall(rn_stall), .rn_group(rn_group), .rn_valid(rn_valid),
        .cm_squash(cm_squash), .cm_rob_squashing(cm_rob_squashing),
        .redir_squash(redir_squash), .redir_mispred(redir_mispred),
        .redir_taken(redir_taken), .redir_seq(redir_seq), .redir_pc(redir_pc),
        .cnt_idle(cnt_idle), .cnt_blocked(cnt_blocked), .cnt_unblock(cnt_unblock),
        .cnt_squash_cyc(cnt_squash_cyc), .cnt_br_mispred(cnt_br_mispred),
        .cnt_ctl_mispred(cnt_ctl_mispred), .cnt_decoded(cnt_decoded),
        .cnt_squashed(cnt_squashed)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    function automatic inst_rec_t plain(logic [15:0] pc, logic [15:0] seq);
        inst_rec_t r;
        r = '0;
        r.valid = 1'b1;
        r.pc = pc;
        r.seq = seq;
        return r;
    endfunction

    function automatic logic [GW-1:0] pack(grp_t g);
        logic [GW-1:0] v;
        v = '0;
        for (int i = 0; i < N; i++) v[i*REC_W +: REC_W] = g[i];
        return v;
    endfunction

    // Expected screening of one group, from the requirements
    task automatic model(input grp_t g, output logic [GW-1:0] og, output logic [N-1:0] ov,
                         output bit hit, output bit is_ctl, output logic [15:0] fpc,
                         output logic [15:0] fseq, output int np, output int ns);
        bit stop;
        stop = 0; og = '0; ov = '0; hit = 0; is_ctl = 0; fpc = '0; fseq = '0; np = 0; ns = 0;
        for (int i = 0; i < N; i++) begin
            if (!stop && g[i].valid) begin
                if (g[i].squashed) ns++;
                else begin
                    og[np*REC_W +: REC_W] = g[i];
                    ov[np] = 1'b1;
                    np++;
                    if (g[i].pred_taken && !g[i].is_ctrl) begin
                        hit = 1; is_ctl = 1; fpc = g[i].pc + 16'd4; fseq = g[i].seq; stop = 1;
                    end else if (g[i].is_ctrl && g[i].dir_uncond && g[i].reg_free &&
                                 (!g[i].pred_taken || g[i].pred_tgt != g[i].real_tgt)) begin
                        hit = 1; fpc = g[i].real_tgt; fseq = g[i].seq; stop = 1;
                    end
                end
            end
        end
    endtask

    task automatic expect_out(string tag, logic [GW-1:0] og, logic [N-1:0] ov);
        check({tag, " rn_valid"}, 128'(rn_valid), 128'(ov));
        for (int i = 0; i < N; i++)
            check({tag, " rn slot"}, 128'(rn_group[i*REC_W +: REC_W]), 128'(og[i*REC_W +: REC_W]));
    endtask

    function automatic inst_rec_t rnd_rec(logic [15:0] pc, logic [15:0] seq);
        inst_rec_t r;
        int k;
        r = '0;
        r.valid = ($urandom % 4) != 0;
        r.pc = pc;
        r.seq = seq;
        r.squashed = ($urandom % 8) == 0;
        k = int'($urandom % 16);
        if (k == 0) begin
            r.pred_taken = 1'b1;
            r.pred_tgt = 16'($urandom);
        end else if (k < 6) begin
            r.is_ctrl = 1'b1;
            r.dir_uncond = 1'($urandom % 4 != 0);
            r.reg_free = 1'($urandom % 4 != 0);
            r.real_tgt = 16'($urandom);
            r.pred_taken = 1'($urandom % 2);
            r.pred_tgt = ($urandom % 3 == 0) ? r.real_tgt + 16'd8 : r.real_tgt;
        end
        return r;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        grp_t g, a, b;
        logic [GW-1:0] og, oa, ob;
        logic [N-1:0] ov, va, vb;
        bit hit, isctl;
        logic [15:0] fpc, fseq;
        int np, ns, npa, npb, nsx;
        logic [31:0] s0, s1, s2, s3, s4, s5, s6, s7;
        int e_dec, e_skip, e_br, e_ctl, e_idle, e_sq;
        logic [31:0] seed_dummy;

        seed_dummy = $urandom(32'd2024);
        rst = 1'b1; fe_group = '0; rn_stall = 0; cm_squash = 0; cm_rob_squashing = 0;
        repeat (3) cyc();
        // R1 reset state
        check("R1 reset rn_valid", 128'(rn_valid), 0);
        check("R1 reset fe_stall", 128'(fe_stall), 0);
        check("R1 reset redirect", 128'(redir_squash), 0);
        check("R1 reset counters", 128'(cnt_decoded | cnt_idle | cnt_blocked), 0);
        rst = 1'b0;

        // R9 idle cycles
        cyc(); cyc();
        check("R9 idle count", 128'(cnt_idle), 2);

        // R1 basic pass-through with R2 squashed record in the middle
        a[0] = plain(16'h100, 16'd1); a[1] = plain(16'h104, 16'd2);
        a[1].squashed = 1'b1;
        a[2] = plain(16'h108, 16'd3); a[3] = '0;
        fe_group = pack(a); cyc();
        og = '0; og[0 +: REC_W] = a[0]; og[REC_W +: REC_W] = a[2];
        expect_out("R1 packed order", og, 4'b0011);
        check("R2 squashed count", 128'(cnt_squashed), 1);
        check("R10 decoded count", 128'(cnt_decoded), 2);

        // R3 non-control predicted taken
        a[0] = plain(16'h200, 16'd10);
        a[1] = plain(16'h204, 16'd11); a[1].pred_taken = 1'b1; a[1].pred_tgt = 16'h900;
        a[2] = plain(16'h208, 16'd12); a[3] = plain(16'h20c, 16'd13);
        fe_group = pack(a); cyc();
        og = '0; og[0 +: REC_W] = a[0]; og[REC_W +: REC_W] = a[1];
        expect_out("R3 truncation", og, 4'b0011);
        check("R3 redirect pc", 128'(redir_pc), 128'(16'h208));
        check("R5 redirect seq", 128'(redir_seq), 11);
        check("R5 redirect flags", 128'({redir_squash, redir_mispred, redir_taken}), 3'b111);
        check("R3 ctl count", 128'(cnt_ctl_mispred), 1);
        // R5 squashing cycle ignores input
        b[0] = plain(16'h300, 16'd20); b[1] = '0; b[2] = '0; b[3] = '0;
        fe_group = pack(b); cyc();
        check("R5 input ignored", 128'(rn_valid), 0);
        check("R5 redirect one cycle", 128'(redir_squash), 0);

        // R4 register-free jump resolved correctly: no redirect
        a[0] = plain(16'h400, 16'd30); a[0].is_ctrl = 1; a[0].dir_uncond = 1; a[0].reg_free = 1;
        a[0].pred_taken = 1; a[0].pred_tgt = 16'h800; a[0].real_tgt = 16'h800;
        a[1] = plain(16'h800, 16'd31);
        a[2] = plain(16'h804, 16'd32); a[2].is_ctrl = 1; a[2].dir_uncond = 1;
        a[2].reg_free = 0; a[2].pred_taken = 0; a[2].real_tgt = 16'h40;
        a[3] = plain(16'h808, 16'd33);
        fe_group = pack(a); cyc();
        expect_out("R4 no resolve", pack(a), 4'b1111);
        check("R4 no redirect", 128'(redir_squash), 0);
        // R4 mismatch on register-free jump
        a[2].reg_free = 1;
        fe_group = pack(a); cyc();
        og = '0; for (int i = 0; i < 3; i++) og[i*REC_W +: REC_W] = a[i];
        expect_out("R4 jump truncation", og, 4'b0111);
        check("R4 redirect pc", 128'(redir_pc), 128'(16'h40));
        check("R4 br count", 128'(cnt_br_mispred), 1);
        fe_group = '0; cyc();

        // R6/R7 two groups parked, drained in order
        a[0] = plain(16'h500, 16'd40); a[1] = plain(16'h504, 16'd41); a[2] = '0; a[3] = '0;
        b[0] = plain(16'h600, 16'd42); b[1] = '0; b[2] = '0; b[3] = plain(16'h60c, 16'd43);
        model(a, oa, va, hit, isctl, fpc, fseq, npa, nsx);
        model(b, ob, vb, hit, isctl, fpc, fseq, npb, nsx);
        s0 = cnt_blocked; s1 = cnt_unblock; s2 = cnt_idle; s3 = cnt_decoded;
        rn_stall = 1; fe_group = pack(a); cyc();
        check("R6 stalled output", 128'(rn_valid), 0);
        check("R6 fetch stall", 128'(fe_stall), 1);
        fe_group = pack(b); cyc();
        fe_group = '0; rn_stall = 0; cyc();
        check("R7 release gap", 128'(rn_valid), 0);
        check("R7 stall held", 128'(fe_stall), 1);
        cyc();
        expect_out("R7 first group", oa, va);
        check("R7 stall while parked", 128'(fe_stall), 1);
        cyc();
        expect_out("R7 second group", ob, vb);
        check("R7 stall released", 128'(fe_stall), 0);
        check("R10 blocked cycles", 128'(cnt_blocked - s0), 2);
        check("R10 unblock cycles", 128'(cnt_unblock - s1), 2);
        check("R9 no idle while blocked", 128'(cnt_idle - s2), 0);
        check("R10 decoded after drain", 128'(cnt_decoded - s3), 128'(npa + npb));

        // R8 commit squash with a parked group
        s0 = cnt_squash_cyc;
        rn_stall = 1; fe_group = pack(a); cyc();
        check("R6 parked", 128'(fe_stall), 1);
        rn_stall = 0; cm_squash = 1; fe_group = '0; cyc();
        check("R8 skid cleared", 128'(fe_stall), 0);
        check("R8 no output", 128'(rn_valid), 0);
        cm_squash = 0; cm_rob_squashing = 1; fe_group = pack(b); cyc();
        check("R8 hold squashing", 128'(rn_valid), 0);
        cm_rob_squashing = 0; cyc();
        check("R8 last squashing cycle", 128'(rn_valid), 0);
        fe_group = pack(a); cyc();
        expect_out("R8 resume", oa, va);
        check("R8 squash cycles", 128'(cnt_squash_cyc - s0), 2);
        fe_group = '0; cyc();

        // Random groups against the bench model
        s0 = cnt_decoded; s1 = cnt_squashed; s2 = cnt_br_mispred; s3 = cnt_ctl_mispred;
        s4 = cnt_idle; s5 = cnt_squash_cyc;
        e_dec = 0; e_skip = 0; e_br = 0; e_ctl = 0; e_idle = 0; e_sq = 0;
        for (int it = 0; it < 400; it++) begin
            for (int i = 0; i < N; i++) g[i] = rnd_rec(16'(16'h1000 + it*16 + i*4), 16'(it*4 + i));
            if (it % 10 == 0) for (int i = 0; i < N; i++) g[i].valid = 1'b0;
            model(g, og, ov, hit, isctl, fpc, fseq, np, ns);
            fe_group = pack(g); cyc();
            expect_out("R1 random group", og, ov);
            check("R5 random redirect", 128'(redir_squash), 128'(hit));
            if (hit) begin
                check("R4 random redirect pc", 128'(redir_pc), 128'(fpc));
                check("R5 random redirect seq", 128'(redir_seq), 128'(fseq));
            end
            e_dec += np; e_skip += ns;
            if (ov == '0 && ns == 0) e_idle++;
            if (hit) begin
                e_sq++;
                if (isctl) e_ctl++; else e_br++;
                fe_group = '0; cyc();
                check("R5 random squash gap", 128'(rn_valid), 0);
            end
        end
        fe_group = '0;
        check("R10 random decoded", 128'(cnt_decoded - s0), 128'(e_dec));
        check("R2 random squashed", 128'(cnt_squashed - s1), 128'(e_skip));
        check("R4 random br count", 128'(cnt_br_mispred - s2), 128'(e_br));
        check("R3 random ctl count", 128'(cnt_ctl_mispred - s3), 128'(e_ctl));
        check("R9 random idle count", 128'(cnt_idle - s4), 128'(e_idle));
        check("R8 random squash cycles", 128'(cnt_squash_cyc - s5), 128'(e_sq));
        s6 = 0; s7 = 0;

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule